// File: doc/BRIEF.md
# SPI-Controlled UART Bridge

This block lets an SPI master run a small serial port using nothing but 16-bit full-duplex frames. The top two bits of each frame name the operation: store the configuration, fetch it, queue a byte for sending, or fetch a received byte. While the command shifts in, the block shifts a status word out. That word says whether a received character is waiting, says whether the one-byte transmit slot is free, and carries the waiting character.

Received characters collect in a small queue. Queued transmit bytes pass through a single holding slot into a shift stage, which sends them on the serial line as 8N1 characters at a fixed number of clocks per bit. The SPI pins are sampled by the system clock, so SCLK has to stay well below the core clock. An active-low interrupt line gives a one-clock falling pulse for each event. The master reacts to the edge and never has to clear the line.

Top module: `spi_uart_bridge`

## Requirements
- R1: A frame takes effect only at the 16th SCLK rising edge seen while CS_n is low. A frame ended early by CS_n rising changes nothing.
- R2: Frame bits 15:14 choose the operation: 11 stores bits 13:0 as configuration, 01 reads the configuration, 10 writes data byte 7:0, 00 reads data. Mode 0 is used: MOSI is sampled on rising SCLK, and MISO changes on falling SCLK with its first bit valid once CS_n is low.
- R3: Every returned word has bit 14 set when the transmit slot is empty. Bit 15 is set when a received byte is waiting. Both are taken when CS_n falls. In data frames bits 7:0 carry that byte and bits 13:8 are zero.
- R4: A read-configuration frame returns the stored configuration in bits 13:0. A write-configuration frame returns zero in bits 13:0.
- R5: The receive queue holds 8 bytes and returns them oldest first. A byte that arrives while the queue is full is dropped.
- R6: A data frame made while the queue is empty returns bit 15 clear and zero in bits 7:0, and it changes nothing.
- R7: A data write fills the transmit slot when the slot is empty and is ignored when it is full. The slot drains into the shifter, which sends a 0 start bit, 8 data bits LSB first and a 1 stop bit, each lasting BIT_CYCLES clocks.
- R8: Configuration bit 13 set limits the receive queue to one entry, and further bytes are dropped.
- R9: Configuration bit 12 (shutdown) empties the receive queue and ignores incoming characters. It starts no transmission and raises no interrupt, but configuration frames still take effect.
- R10: irq_n drops low for one clock when a byte enters the receive queue with configuration bit 10 set, or when the transmit slot drains with bit 11 set. Otherwise it stays high.
- R11: Write-data frames also remove the waiting received byte that they return, in the same way as read-data frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Command bits from the master |
| spi_miso | output | 1 | Status bits to the master |
| uart_txd | output | 1 | Serial transmit line, idle high |
| uart_rxd | input | 1 | Serial receive line, idle high |
| irq_n | output | 1 | Active-low one-clock event pulse |

## Verification
A behavioural queue model follows every received character. The returned words are checked after bursts of one, three and ten characters: the short bursts show arrival order, and the long one tells a queue that drops at 8 from one that wraps or overwrites. Three data writes back to back check that the slot's empty flag is taken at CS_n fall: the second write still sees an empty slot and the third sees it full. A shortened configuration frame, a one-deep queue and a shutdown with a byte held in the slot each give different returned words and line traffic, and so tell the affected path apart from the normal one. Interrupt edges are counted over each phase to show that dropped bytes and disabled sources stay silent.

// File: rtl/spiub_pkg.sv
`timescale 1ns/1ps
package spiub_pkg;
   localparam int FRAME_W = 16;
   localparam int CFG_W   = FRAME_W - 2;

   typedef enum logic [1:0] {
      OP_RD_DAT = 2'b00,
      OP_RD_CFG = 2'b01,
      OP_WR_DAT = 2'b10,
      OP_WR_CFG = 2'b11
   } spiub_op_e;

   // configuration bit positions
   localparam int CB_FIFO_OFF = 13;
   localparam int CB_SHDN     = 12;
   localparam int CB_IE_TXE   = 11;
   localparam int CB_IE_RXA   = 10;
endpackage

// File: rtl/spiub_spi_slave.sv
`timescale 1ns/1ps
module spiub_spi_slave #(
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               miso,
   input  logic [1:0]         st_hi,
   input  logic [FRAME_W-3:0] low_bits,
   output logic               frame_start,
   output logic [1:0]         op_bits,
   output logic               commit,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int CNT_W = $clog2(FRAME_W) + 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] OP_DONE  = CNT_W'(2);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FRAME_W < 4) begin : g_bad_frame
         $error("FRAME_W too small");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
   logic sclk_q, cs_q;
   logic sclk_s, cs_s, mosi_s;
   logic rise, fall;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] in_sr, out_sr;
   logic               done;
   logic               commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sy <= '0;
         cs_sy   <= '1;
         mosi_sy <= '0;
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
      end else begin
         sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
         cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
         mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
         sclk_q  <= sclk_s;
         cs_q    <= cs_s;
      end
   end

   assign sclk_s      = sclk_sy[SYNC_STAGES-1];
   assign cs_s        = cs_sy[SYNC_STAGES-1];
   assign mosi_s      = mosi_sy[SYNC_STAGES-1];
   assign rise        = sclk_s & ~sclk_q;
   assign fall        = ~sclk_s & sclk_q;
   assign frame_start = ~cs_s & cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         in_sr    <= '0;
         out_sr   <= '0;
         done     <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (cs_s) begin
            bit_cnt <= '0;
            done    <= 1'b0;
            out_sr  <= '0;
         end else if (frame_start) begin
            out_sr  <= {st_hi, {(FRAME_W-2){1'b0}}};
            bit_cnt <= '0;
            done    <= 1'b0;
         end else if (!done) begin
            if (rise) begin
               in_sr   <= {in_sr[FRAME_W-2:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_BIT) begin
                  commit_q <= 1'b1;
                  done     <= 1'b1;
               end
            end
            if (fall) begin
               if (bit_cnt == OP_DONE) out_sr <= {low_bits, 2'b00};
               else                    out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso    = out_sr[FRAME_W-1];
   assign op_bits = in_sr[1:0];
   assign commit  = commit_q;
   assign rx_word = in_sr;

   // R1: a frame only takes effect while select is still low
   assert_commit_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !cs_s);
   // R1: only one commit per selected frame
   assert_single_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
endmodule

// File: rtl/spiub_rx_fifo.sv
`timescale 1ns/1ps
module spiub_rx_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         one_deep,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         empty,
   output logic [W-1:0] head,
   output logic         accepted
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          room, pop_ok;

   assign empty    = (count == '0);
   assign room     = one_deep ? empty : (count != FULL_CNT);
   assign accepted = push & room & ~clear;
   assign pop_ok   = pop & ~empty & ~clear;
   assign head     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accepted) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accepted) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)   rd_ptr <= rd_ptr + 1'b1;
         case ({accepted, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   assert_empty_pop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
   assert_one_deep_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (one_deep && !empty && !clear) |=> count <= $past(count));
   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> empty);
endmodule

// File: rtl/spiub_uart_tx.sv
`timescale 1ns/1ps
module spiub_uart_tx #(
   parameter int BIT_CYCLES = 48,
   parameter int W          = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         wr_en,
   input  logic [W-1:0] wr_byte,
   output logic         hold_empty,
   output logic         hold_drained,
   output logic         txd
);
   localparam int FB   = W + 2;
   localparam int TW   = $clog2(BIT_CYCLES);
   localparam int LW   = $clog2(FB + 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(BIT_CYCLES - 1);
   localparam logic [LW-1:0] FB_CNT    = LW'(FB);

   generate
      if (BIT_CYCLES < 4) begin : g_bad_bit
         $error("BIT_CYCLES must be at least 4");
      end
   endgenerate

   logic         hold_full;
   logic [W-1:0] hold_byte;
   logic [FB-1:0] sh;
   logic [LW-1:0] left;
   logic [TW-1:0] tick;
   logic          busy, load;

   assign load         = run & hold_full & ~busy;
   assign hold_empty   = ~hold_full;
   assign hold_drained = load;
   assign txd          = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_byte <= '0;
      end else if (load) begin
         hold_full <= 1'b0;
      end else if (wr_en && !hold_full) begin
         hold_full <= 1'b1;
         hold_byte <= wr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         tick <= '0;
         busy <= 1'b0;
      end else if (!run) begin
         busy <= 1'b0;
         tick <= '0;
      end else if (load) begin
         sh   <= {1'b1, hold_byte, 1'b0};
         left <= FB_CNT;
         tick <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (tick == TICK_LAST) begin
            tick <= '0;
            sh   <= {1'b1, sh[FB-1:1]};
            left <= left - 1'b1;
            if (left == LW'(1)) busy <= 1'b0;
         end else begin
            tick <= tick + 1'b1;
         end
      end
   end

   // R7: a write into a full slot leaves the held byte untouched
   assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hold_empty) |=> $stable(hold_byte));
   // R9: a stopped engine keeps the line idle
   assert_stopped_line_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> txd);
endmodule

// File: rtl/spiub_uart_rx.sv
`timescale 1ns/1ps
module spiub_uart_rx #(
   parameter int BIT_CYCLES  = 48,
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         rxd,
   output logic         valid,
   output logic [W-1:0] data
);
   localparam int TW = $clog2(BIT_CYCLES);
   localparam int IW = $clog2(W);
   localparam logic [TW-1:0] TICK_LAST = TW'(BIT_CYCLES - 1);
   localparam logic [TW-1:0] TICK_HALF = TW'(BIT_CYCLES / 2 - 1);
   localparam logic [IW-1:0] IDX_LAST  = IW'(W - 1);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

   logic [SYNC_STAGES-1:0] rx_sy;
   logic                   rx_s;
   rx_state_e              st;
   logic [TW-1:0]          cnt;
   logic [IW-1:0]          idx;
   logic [W-1:0]           sh;

   assign rx_s = rx_sy[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_sy <= '1;
      else        rx_sy <= {rx_sy[SYNC_STAGES-2:0], rxd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         idx   <= '0;
         sh    <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= 1'b0;
         if (!run) begin
            st <= RX_IDLE;
         end else begin
            case (st)
               RX_IDLE: if (!rx_s) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: if (cnt == TICK_HALF) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= rx_s ? RX_IDLE : RX_DATA;
               end else cnt <= cnt + 1'b1;
               RX_DATA: if (cnt == TICK_LAST) begin
                  cnt <= '0;
                  sh  <= {rx_s, sh[W-1:1]};
                  if (idx == IDX_LAST) st <= RX_STOP;
                  else                 idx <= idx + 1'b1;
               end else cnt <= cnt + 1'b1;
               RX_STOP: if (cnt == TICK_LAST) begin
                  st    <= RX_IDLE;
                  valid <= rx_s;
                  data  <= sh;
               end else cnt <= cnt + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assert_rx_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
endmodule

// File: rtl/spi_uart_bridge.sv
`timescale 1ns/1ps
module spi_uart_bridge
   import spiub_pkg::*;
#(
   parameter int RX_DEPTH    = 8,
   parameter int BIT_CYCLES  = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sclk,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic uart_txd,
   input  logic uart_rxd,
   output logic irq_n
);
   localparam int DW = 8;

   logic [CFG_W-1:0]   cfg;
   logic               shdn, fifo_off;
   logic               frame_start, commit;
   logic [1:0]         op_bits;
   logic [FRAME_W-1:0] rx_word;
   logic [FRAME_W-3:0] low_bits;
   logic               fifo_empty, fifo_accepted;
   logic [DW-1:0]      fifo_head;
   logic               rx_valid;
   logic [DW-1:0]      rx_data;
   logic               hold_empty, hold_drained;
   logic               snap_valid;
   logic [DW-1:0]      snap_byte;
   logic               is_data_op, pop, tx_wr, irq_pend;
   spiub_op_e          live_op, done_op;

   assign shdn     = cfg[CB_SHDN];
   assign fifo_off = cfg[CB_FIFO_OFF];
   assign live_op  = spiub_op_e'(op_bits);
   assign done_op  = spiub_op_e'(rx_word[FRAME_W-1:FRAME_W-2]);

   spiub_spi_slave #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_spi (
      .clk, .rst_n,
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
      .st_hi({~fifo_empty, hold_empty}),
      .low_bits, .frame_start, .op_bits, .commit, .rx_word
   );

   // status taken when select falls; data returned with it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_valid <= 1'b0;
         snap_byte  <= '0;
      end else if (frame_start) begin
         snap_valid <= ~fifo_empty;
         snap_byte  <= fifo_head;
      end
   end

   always_comb begin
      case (live_op)
         OP_RD_CFG:            low_bits = cfg;
         OP_RD_DAT, OP_WR_DAT: low_bits = snap_valid ? {{(CFG_W-DW){1'b0}}, snap_byte} : '0;
         default:              low_bits = '0;
      endcase
   end

   assign is_data_op = (done_op == OP_RD_DAT) || (done_op == OP_WR_DAT);
   assign pop        = commit & is_data_op & snap_valid;
   assign tx_wr      = commit & (done_op == OP_WR_DAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cfg <= '0;
      else if (commit && done_op == OP_WR_CFG)  cfg <= rx_word[CFG_W-1:0];
   end

   spiub_rx_fifo #(.DEPTH(RX_DEPTH), .W(DW)) u_fifo (
      .clk, .rst_n,
      .clear(shdn), .one_deep(fifo_off),
      .push(rx_valid), .push_data(rx_data), .pop,
      .empty(fifo_empty), .head(fifo_head), .accepted(fifo_accepted)
   );

   spiub_uart_rx #(.BIT_CYCLES(BIT_CYCLES), .W(DW), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk, .rst_n, .run(~shdn), .rxd(uart_rxd), .valid(rx_valid), .data(rx_data)
   );

   spiub_uart_tx #(.BIT_CYCLES(BIT_CYCLES), .W(DW)) u_tx (
      .clk, .rst_n, .run(~shdn), .wr_en(tx_wr), .wr_byte(rx_word[DW-1:0]),
      .hold_empty, .hold_drained, .txd(uart_txd)
   );

   assign irq_pend = ~shdn & ((cfg[CB_IE_RXA] & fifo_accepted) |
                              (cfg[CB_IE_TXE] & hold_drained));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~irq_pend;
   end

   // R3: a byte is removed only when one was reported
   assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !fifo_empty);
   // R1: configuration changes only through a completed frame
   assert_cfg_needs_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(cfg));
   // R9: no event pulse while shut down
   assert_quiet_in_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
      shdn |=> irq_n);
   // R10: a pulse always has an enabled source behind it
   assert_irq_has_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> $past(cfg[CB_IE_RXA] | cfg[CB_IE_TXE]));
endmodule

// File: tb/test_spi_uart_bridge.sv
`timescale 1ns/1ps
module test_spi_uart_bridge;
   localparam int BITC = 48;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, rxd = 1'b1;
   logic miso, txd, irq_n;

   int n_chk = 0, n_fail = 0, irq_cnt = 0;
   logic [7:0] model_q[$];
   logic [7:0] tx_seen[$];
   logic [13:0] model_cfg = '0;

   always #2 clk = ~clk;

   spi_uart_bridge #(.RX_DEPTH(8), .BIT_CYCLES(BITC), .SYNC_STAGES(2)) i_spi_uart_bridge (
      .clk, .rst_n, .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
      .uart_txd(txd), .uart_rxd(rxd), .irq_n
   );

   always @(negedge irq_n) if (rst_n) irq_cnt++;

   // serial line monitor for the transmit side
   initial begin
      forever begin
         logic [7:0] b;
         @(negedge txd);
         repeat (BITC/2) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = txd;
         end
         repeat (BITC) @(negedge clk);
         n_chk++;
         if (txd !== 1'b1) begin
            n_fail++;
            $display("FAIL R7 stop bit act=%b exp=1", txd);
         end
         tx_seen.push_back(b);
      end
   end

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic spi_xfer(input logic [15:0] cmd, input int nbits, output logic [15:0] resp);
      resp = '0;
      cs_n = 1'b0;
      mosi = cmd[15];
      wait_clks(HALF);
      for (int i = 15; i >= 16 - nbits; i--) begin
         sclk = 1'b1;
         resp[i] = miso;
         wait_clks(HALF);
         sclk = 1'b0;
         if (i > 0) mosi = cmd[i-1];
         wait_clks(HALF);
      end
      cs_n = 1'b1;
      wait_clks(HALF);
   endtask

   task automatic wr_cfg(input string tag, input logic [13:0] c, input logic txe);
      logic [15:0] r;
      spi_xfer({2'b11, c}, 16, r);
      check16(tag, r, {model_q.size() != 0, txe, 14'h0});
      model_cfg = c;
      if (c[12]) model_q.delete();
   endtask

   // data frame; expected word from the queue model
   task automatic data_frame(input string tag, input logic [15:0] cmd, input logic txe);
      logic [15:0] r, e;
      if (model_q.size() != 0) e = {1'b1, txe, 6'h0, model_q.pop_front()};
      else                     e = {1'b0, txe, 14'h0};
      spi_xfer(cmd, 16, r);
      check16(tag, r, e);
   endtask

   task automatic uart_send(input logic [7:0] b);
      logic [9:0] f;
      f = {1'b1, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         rxd = f[i];
         wait_clks(BITC);
      end
      wait_clks(BITC);
      if (!model_cfg[12]) begin
         if (model_cfg[13] ? (model_q.size() == 0) : (model_q.size() < 8))
            model_q.push_back(b);
      end
   endtask

   task automatic check_irq(input string tag, input int base, input int delta);
      n_chk++;
      if (irq_cnt - base != delta) begin
         n_fail++;
         $display("FAIL %s irq edges act=%0d exp=%0d", tag, irq_cnt - base, delta);
      end
   endtask

   task automatic check_tx(input string tag, input logic [7:0] exp[$]);
      n_chk++;
      if (tx_seen != exp) begin
         n_fail++;
         $display("FAIL %s tx count act=%0d exp=%0d", tag, tx_seen.size(), exp.size());
      end
      tx_seen.delete();
   endtask

   initial begin
      logic [15:0] r;
      int base;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(5);

      // reset state
      check16("R10 irq idle", {15'h0, irq_n}, 16'h0001);
      check16("R7 txd idle", {15'h0, txd}, 16'h0001);
      spi_xfer(16'h4000, 16, r);
      check16("R4 reset cfg read", r, 16'h4000);
      data_frame("R6 empty read", 16'h0000, 1'b1);

      // configuration store and readback
      wr_cfg("R4 cfg write returns zero", 14'h0405, 1'b1);
      spi_xfer(16'h4000, 16, r);
      check16("R2 cfg readback", r, 16'h4405);

      // frame cut short
      spi_xfer(16'hC0FF, 10, r);
      wait_clks(20);
      spi_xfer(16'h4000, 16, r);
      check16("R1 short frame discarded", r, 16'h4405);

      // short burst
      base = irq_cnt;
      uart_send(8'h5A); uart_send(8'hC3); uart_send(8'h01);
      check_irq("R10 rx events", base, 3);
      for (int i = 0; i < 3; i++) data_frame("R3 R5 ordered read", 16'h0000, 1'b1);
      data_frame("R6 drained read", 16'h0000, 1'b1);

      // overflow burst
      base = irq_cnt;
      for (int i = 0; i < 10; i++) uart_send(8'(8'h10 + i));
      check_irq("R10 R5 dropped byte silent", base, 8);
      for (int i = 0; i < 9; i++) data_frame("R5 overflow read", 16'h0000, 1'b1);

      // write data pops a received byte
      base = irq_cnt;
      uart_send(8'h77);
      data_frame("R11 write pops", 16'h8041, 1'b1);
      data_frame("R7 slot drained", 16'h0000, 1'b1);
      wait_clks(12*BITC);
      check_tx("R7 serial byte 41", '{8'h41});
      check_irq("R10 tx source disabled", base, 1);

      // three writes back to back
      wr_cfg("R2 enable tx event", 14'h0C05, 1'b1);
      base = irq_cnt;
      data_frame("R3 first write", 16'h8031, 1'b1);
      data_frame("R3 second write sees empty", 16'h8032, 1'b1);
      data_frame("R7 third write sees full", 16'h8033, 1'b0);
      wait_clks(25*BITC);
      check_tx("R7 full write ignored", '{8'h31, 8'h32});
      check_irq("R10 tx drain events", base, 2);

      // single-entry mode
      wr_cfg("R8 fifo off", 14'h2405, 1'b1);
      base = irq_cnt;
      uart_send(8'hA1); uart_send(8'hA2); uart_send(8'hA3);
      check_irq("R8 R10 one accepted", base, 1);
      data_frame("R8 first kept", 16'h0000, 1'b1);
      data_frame("R8 rest dropped", 16'h0000, 1'b1);

      // shutdown
      wr_cfg("R9 fifo on", 14'h0405, 1'b1);
      uart_send(8'h55); uart_send(8'h66);
      wr_cfg("R9 enter shutdown", 14'h1405, 1'b1);
      data_frame("R9 queue cleared", 16'h0000, 1'b1);
      spi_xfer(16'h4000, 16, r);
      check16("R9 cfg still written", r, 16'h5405);
      base = irq_cnt;
      uart_send(8'h99);
      check_irq("R9 no event", base, 0);
      data_frame("R9 rx ignored", 16'h0000, 1'b1);
      data_frame("R9 write held", 16'h8044, 1'b1);
      wait_clks(12*BITC);
      check_tx("R9 nothing sent", '{});
      data_frame("R9 slot stays full", 16'h0000, 1'b0);
      wr_cfg("R9 leave shutdown", 14'h0405, 1'b0);
      wait_clks(12*BITC);
      check_tx("R9 held byte sent", '{8'h44});

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait_clks(200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule